// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block tracks the operating state of a DRAM controller. There are four stable states: initialisation (`INIT_MEM`), configuration (`CONFIG`), normal traffic (`ACCESS`) and low power (`LOW_PWR`). There are also four transient request states. Each transient state stands for a move that has started but not yet finished: `CFG_REQ`, `ACC_REQ`, `LP_ENTRY` and `LP_EXIT`.

Software-side logic starts a move by pulsing `req_wr` with a request code. The block accepts only the moves that are legal from the current stable state and ignores every other request. An accepted move enters its transient state. The transient state holds for at least `DWELL` cycles. After that it settles on the first cycle in which the completion handshake `step_ack` is high.

The current state is always visible on the 3-bit `stat` port. The only way out of low power is a wakeup to access, so getting from low power to configuration takes two separate requests.

The named transitions are:
- config-from-init: `INIT_MEM`→`CFG_REQ`→`CONFIG`
- config-from-access: `ACCESS`→`CFG_REQ`→`CONFIG`
- go: `CONFIG`→`ACC_REQ`→`ACCESS`
- sleep: `ACCESS`→`LP_ENTRY`→`LOW_PWR`
- wakeup: `LOW_PWR`→`LP_EXIT`→`ACCESS`
- return-to-init: `CONFIG`→`INIT_MEM`, taken directly in one cycle

Top module: `ddr_opstate_ctrl`

## Requirements
- R1: After reset, `stat` is 0 (`INIT_MEM`) and `busy` is 0.
- R2: The `stat` codes are INIT_MEM=0, CONFIG=1, CFG_REQ=2, ACCESS=3, ACC_REQ=4, LOW_PWR=5, LP_ENTRY=6 and LP_EXIT=7. The `req_code` codes are init=0, config=1, go=2, sleep=3 and wakeup=4; codes 5 to 7 are not requests.
- R3: A config request in INIT_MEM shows CFG_REQ from the next cycle for `DWELL` cycles, then CONFIG (with `step_ack` high).
- R4: A config request in ACCESS passes through CFG_REQ for `DWELL` cycles and settles in CONFIG.
- R5: A go request in CONFIG passes through ACC_REQ for `DWELL` cycles and settles in ACCESS.
- R6: A sleep request in ACCESS passes through LP_ENTRY for `DWELL` cycles and settles in LOW_PWR.
- R7: A wakeup request in LOW_PWR passes through LP_EXIT for `DWELL` cycles and settles in ACCESS.
- R8: In LOW_PWR, the init, config, go and sleep requests are ignored; only wakeup leaves the state.
- R9: In any stable state, a request that is not listed as legal for that state (including codes 5 to 7) leaves `stat` unchanged.
- R10: Requests that arrive while a transient state is active are ignored, and the move completes to its original target on schedule.
- R11: A transient state does not settle while `step_ack` is low, even after `DWELL` cycles. Once the dwell has elapsed, it settles one cycle after `step_ack` is seen high.
- R12: An init request in CONFIG returns `stat` to INIT_MEM on the next cycle, with no transient state.
- R13: `busy` is 1 exactly when `stat` is a transient code (2, 4, 6 or 7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | One-cycle strobe that presents a state-change request |
| req_code | input | 3 | Request code, sampled when `req_wr` is high |
| step_ack | input | 1 | Completion handshake for the transient state that is in progress |
| stat | output | 3 | Current operating state code |
| busy | output | 1 | High while a transient request state is active |

## Verification
The hardest case to reach is a transient state that has finished its dwell but is held by a low `step_ack`. The bench drops `step_ack` before it issues a sleep request. It then watches LP_ENTRY persist well past `DWELL` cycles and raises the handshake on a chosen cycle to time the settle.

A second hard case is a request that lands in the middle of a transition. The bench issues it one cycle after a config request and counts cycles to confirm that the original target is still reached on time. Low power is reached only through a full sleep sequence, so each request there that should be ignored is checked after that setup.

// File: rtl/osc_pkg.sv
package osc_pkg;

    // Operating state codes (visible on stat)
    typedef enum logic [2:0] {
        ST_INIT_MEM = 3'd0,
        ST_CONFIG   = 3'd1,
        ST_CFG_REQ  = 3'd2,
        ST_ACCESS   = 3'd3,
        ST_ACC_REQ  = 3'd4,
        ST_LOW_PWR  = 3'd5,
        ST_LP_ENTRY = 3'd6,
        ST_LP_EXIT  = 3'd7
    } opstate_e;

    // Request codes (req_code); 5..7 are not requests
    typedef enum logic [2:0] {
        RQ_INIT   = 3'd0,
        RQ_CONFIG = 3'd1,
        RQ_GO     = 3'd2,
        RQ_SLEEP  = 3'd3,
        RQ_WAKE   = 3'd4
    } opreq_e;

endpackage

// File: rtl/osc_req_filter.sv
module osc_req_filter
    import osc_pkg::*;
(
    input  opstate_e   cur,
    input  logic       req_wr,
    input  logic [2:0] req_code,
    output logic       accept,
    output opstate_e   tgt
);

    always_comb begin
        accept = 1'b0;
        tgt    = cur;
        if (req_wr) begin
            unique case (cur)
                ST_INIT_MEM: begin
                    if (req_code == RQ_CONFIG) begin
                        accept = 1'b1;
                        tgt    = ST_CFG_REQ;
                    end
                end
                ST_CONFIG: begin
                    if (req_code == RQ_GO) begin
                        accept = 1'b1;
                        tgt    = ST_ACC_REQ;
                    end else if (req_code == RQ_INIT) begin
                        accept = 1'b1;
                        tgt    = ST_INIT_MEM;
                    end
                end
                ST_ACCESS: begin
                    if (req_code == RQ_CONFIG) begin
                        accept = 1'b1;
                        tgt    = ST_CFG_REQ;
                    end else if (req_code == RQ_SLEEP) begin
                        accept = 1'b1;
                        tgt    = ST_LP_ENTRY;
                    end
                end
                ST_LOW_PWR: begin
                    if (req_code == RQ_WAKE) begin
                        accept = 1'b1;
                        tgt    = ST_LP_EXIT;
                    end
                end
                ST_CFG_REQ, ST_ACC_REQ, ST_LP_ENTRY, ST_LP_EXIT: begin
                    accept = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/osc_dwell_timer.sv
module osc_dwell_timer #(
    parameter int DWELL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    generate
        if (DWELL <= 1) begin : g_nodwell
            assign expired = run;
        end else begin : g_count
            localparam int CW = $clog2(DWELL);
            localparam logic [CW-1:0] LAST = CW'(DWELL - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (!rst_n || !run)
                    cnt <= '0;
                else if (cnt != LAST)
                    cnt <= cnt + 1'b1;
            end

            assign expired = run && (cnt == LAST);

            // R11
            dwell_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> !expired);
        end
    endgenerate

endmodule

// File: rtl/osc_state_core.sv
module osc_state_core
    import osc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     accept,
    input  opstate_e tgt,
    input  logic     expired,
    input  logic     step_ack,
    output opstate_e state,
    output logic     busy
);

    opstate_e nxt;
    opstate_e settle;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_INIT_MEM;
        else
            state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_CFG_REQ:  settle = ST_CONFIG;
            ST_ACC_REQ:  settle = ST_ACCESS;
            ST_LP_ENTRY: settle = ST_LOW_PWR;
            ST_LP_EXIT:  settle = ST_ACCESS;
            default:     settle = state;
        endcase
    end

    always_comb begin
        nxt = state;
        if (accept)
            nxt = tgt;
        else if (busy && expired && step_ack)
            nxt = settle;
    end

    always_comb begin
        unique case (state)
            ST_CFG_REQ, ST_ACC_REQ, ST_LP_ENTRY, ST_LP_EXIT: busy = 1'b1;
            default:                                          busy = 1'b0;
        endcase
    end

    // R8
    lp_exit_only_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW_PWR) |=> (state == ST_LOW_PWR || state == ST_LP_EXIT));

    // R11
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_ack) |=> $stable(state));

    // R10
    cfg_req_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CFG_REQ) |=> (state == ST_CFG_REQ || state == ST_CONFIG));

    // R10
    lp_entry_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LP_ENTRY) |=> (state == ST_LP_ENTRY || state == ST_LOW_PWR));

endmodule

// File: rtl/ddr_opstate_ctrl.sv
module ddr_opstate_ctrl
    import osc_pkg::*;
#(
    parameter int DWELL = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_wr,
    input  logic [2:0] req_code,
    input  logic       step_ack,
    output logic [2:0] stat,
    output logic       busy
);

    opstate_e cur_st;
    opstate_e req_tgt;
    logic     req_ok;
    logic     dwell_done;
    logic     core_busy;

    osc_req_filter u_filter (
        .cur      (cur_st),
        .req_wr   (req_wr),
        .req_code (req_code),
        .accept   (req_ok),
        .tgt      (req_tgt)
    );

    osc_dwell_timer #(.DWELL(DWELL)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (core_busy),
        .expired (dwell_done)
    );

    osc_state_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (req_ok),
        .tgt      (req_tgt),
        .expired  (dwell_done),
        .step_ack (step_ack),
        .state    (cur_st),
        .busy     (core_busy)
    );

    assign stat = cur_st;
    assign busy = core_busy;

    // R9
    settled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !req_wr) |=> $stable(stat));

    // R12
    init_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == 3'd1 && req_wr && req_code == 3'd0) |=> (stat == 3'd0));

    // R7
    wake_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == 3'd7) |=> (stat == 3'd7 || stat == 3'd3));

endmodule

// File: tb/test_ddr_opstate_ctrl.sv
`timescale 1ns/1ps
module test_ddr_opstate_ctrl;

    localparam int DWELL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_wr = 1'b0;
    logic [2:0] req_code = 3'd0;
    logic       step_ack = 1'b1;
    logic [2:0] stat;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ddr_opstate_ctrl #(.DWELL(DWELL)) i_ddr_opstate_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_wr   (req_wr),
        .req_code (req_code),
        .step_ack (step_ack),
        .stat     (stat),
        .busy     (busy)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_stat(input logic [2:0] exp, input string tag);
        logic eb;
        eb = (exp == 3'd2 || exp == 3'd4 || exp == 3'd6 || exp == 3'd7);
        n_chk++;
        if (stat !== exp) begin
            n_fail++;
            $display("FAIL %s: stat=%0d expected %0d", tag, stat, exp);
        end
        n_chk++;
        if (busy !== eb) begin
            n_fail++;
            $display("FAIL %s R13: busy=%0b expected %0b (stat exp %0d)", tag, busy, eb, exp);
        end
    endtask

    // pulse one request; returns at the negedge after the sampling edge
    task automatic issue(input logic [2:0] code);
        req_wr   = 1'b1;
        req_code = code;
        step();
        req_wr   = 1'b0;
        req_code = 3'd0;
    endtask

    task automatic transit(input logic [2:0] code, input logic [2:0] mid,
                           input logic [2:0] fin, input string tag);
        issue(code);
        check_stat(mid, tag);
        for (int i = 1; i < DWELL; i++) begin
            step();
            check_stat(mid, tag);
        end
        step();
        check_stat(fin, tag);
    endtask

    task automatic t_reset();
        check_stat(3'd0, "R1 R2 reset");
    endtask

    task automatic t_init_illegal();
        issue(3'd2); check_stat(3'd0, "R9 go in init");
        issue(3'd3); check_stat(3'd0, "R9 sleep in init");
        issue(3'd4); check_stat(3'd0, "R9 wake in init");
        issue(3'd6); check_stat(3'd0, "R9 code6 in init");
    endtask

    task automatic t_init_to_cfg();
        transit(3'd1, 3'd2, 3'd1, "R3 R2 config from init");
    endtask

    task automatic t_init_return();
        issue(3'd0); check_stat(3'd0, "R12 init from config");
        transit(3'd1, 3'd2, 3'd1, "R3 config again");
    endtask

    task automatic t_cfg_illegal();
        issue(3'd3); check_stat(3'd1, "R9 sleep in config");
        issue(3'd4); check_stat(3'd1, "R9 wake in config");
        issue(3'd1); check_stat(3'd1, "R9 config in config");
        issue(3'd7); check_stat(3'd1, "R9 code7 in config");
    endtask

    task automatic t_go();
        transit(3'd2, 3'd4, 3'd3, "R5 go");
    endtask

    task automatic t_acc_cfg();
        issue(3'd4); check_stat(3'd3, "R9 wake in access");
        transit(3'd1, 3'd2, 3'd1, "R4 config from access");
        transit(3'd2, 3'd4, 3'd3, "R5 go back");
    endtask

    task automatic t_sleep();
        transit(3'd3, 3'd6, 3'd5, "R6 sleep");
    endtask

    task automatic t_lp_ignore();
        issue(3'd1); check_stat(3'd5, "R8 config in low power");
        issue(3'd2); check_stat(3'd5, "R8 go in low power");
        issue(3'd0); check_stat(3'd5, "R8 init in low power");
        issue(3'd3); check_stat(3'd5, "R8 sleep in low power");
    endtask

    task automatic t_wake();
        transit(3'd4, 3'd7, 3'd3, "R7 wakeup");
    endtask

    task automatic t_mid_request();
        issue(3'd1);
        check_stat(3'd2, "R10 enter");
        issue(3'd3);
        check_stat(3'd2, "R10 sleep mid");
        for (int i = 2; i < DWELL; i++) begin
            step();
            check_stat(3'd2, "R10 hold");
        end
        step();
        check_stat(3'd1, "R10 settle");
        transit(3'd2, 3'd4, 3'd3, "R5 go after");
    endtask

    task automatic t_ack_hold();
        step_ack = 1'b0;
        issue(3'd3);
        check_stat(3'd6, "R11 enter");
        for (int i = 0; i < DWELL + 3; i++) begin
            step();
            check_stat(3'd6, "R11 held");
        end
        step_ack = 1'b1;
        step();
        check_stat(3'd5, "R11 settle after ack");
        transit(3'd4, 3'd7, 3'd3, "R7 wake after hold");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_init_illegal();
        t_init_to_cfg();
        t_init_return();
        t_cfg_illegal();
        t_go();
        t_acc_cfg();
        t_sleep();
        t_lp_ignore();
        t_wake();
        t_mid_request();
        t_ack_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: done=0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule